// File: doc/BRIEF.md
# Per-Block Cipher Key Mixer with Physical Fingerprint Words

This block builds a fresh key for a fixed-length block cipher before every plaintext block. It does not keep one stored key. It combines a key supplied by the user with a word returned by an on-chip physically unclonable array. The combined vector is compressed down to the cipher's key width. The cipher core and the fingerprint cells sit outside this block.

An internal challenge generator chooses which fingerprint word is fetched for each block. The generator is a linear feedback shift register seeded from the user key, and it advances once per produced key. After a programmable number of words it returns to its seed, so the key sequence repeats with that period. Loading a user key starts the whole sequence over.

For each block the cipher side raises a request. The block then runs one request/acknowledge exchange with the fingerprint array and presents the new key with a one-cycle valid pulse.

Top module: `pkx_key_mixer`

## Requirements
- R1: After reset, `puf_req`, `key_vld` and `blk_rdy` are all low. No block request is taken before a user key has been loaded.
- R2: A `ukey_load` pulse stores `ukey_in` and the wrap period, and `blk_rdy` is high in the next cycle. The first challenge is the seed: the low 8 bits of the user key, replaced by 8'h01 when those bits are zero.
- R3: When `blk_req` is high while `blk_rdy` is high, `puf_req` rises in the next cycle and `blk_rdy` falls. `puf_req` and `puf_chal` then hold steady until `puf_ack`. A `blk_req` during a fetch is ignored: it causes no extra fetch and no extra challenge step.
- R4: `key_vld` is a single-cycle pulse in the cycle after the edge that samples `puf_ack`, and `puf_req` is low in that cycle. `key_out` equals the XOR of the 32-bit slices of the vector formed by the user key (upper bits) followed by the fingerprint word (lower bits). For the default widths that is ukey[63:32] ^ ukey[31:0] ^ word. A short last slice would be zero-padded at its top.
- R5: Each accepted fingerprint word steps the challenge to {s[6:0], ^(s & 8'hB8)}, unless a wrap applies.
- R6: Once `period_in` words have been used since the last load, the next challenge is the seed again. A period of 0 is treated as 1.
- R7: A `ukey_load` during a fetch drops `puf_req` in the next cycle and gives no `key_vld` for the aborted fetch. The next challenge is the new key's seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ukey_load | input | 1 | Load pulse for user key and period |
| ukey_in | input | 64 | User key |
| period_in | input | 8 | Number of fingerprint words before the sequence wraps |
| blk_req | input | 1 | Request a key for the next plaintext block |
| blk_rdy | output | 1 | A block request would be accepted now |
| puf_req | output | 1 | Fetch request to the fingerprint array |
| puf_chal | output | 8 | Challenge for the current fetch |
| puf_ack | input | 1 | Fingerprint word is valid |
| puf_word | input | 32 | Fingerprint response word |
| key_out | output | 32 | Enhanced cipher key |
| key_vld | output | 1 | One-cycle pulse when `key_out` is new |

## Verification
The hardest cases to reach are a key reload that arrives while a fetch is still outstanding, and a block request that lands in the middle of a fetch. The stimulus holds back the acknowledge for several cycles and injects a load or a request inside that window. It then checks that no key appears for the aborted fetch and that the next challenge is the correct one. Wrap behaviour is reached by running more fetches than the period, both with a period of 0 and with a small nonzero period. The seed-of-zero case is reached by loading a key whose low byte is zero.

// File: rtl/pkx_pkg.sv
package pkx_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FETCH = 2'd2
    } pkx_state_e;
endpackage

// File: rtl/pkx_chal_gen.sv
module pkx_chal_gen #(
    parameter int          CHAL_W = 8,
    parameter logic [CHAL_W-1:0] TAPS = 8'hB8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [CHAL_W-1:0] seed_in,
    input  logic              advance,
    input  logic              wrap,
    output logic [CHAL_W-1:0] chal
);
    typedef struct packed {
        logic [CHAL_W-1:0] seed;
        logic [CHAL_W-1:0] state;
    } gen_regs_t;

    gen_regs_t r_d, r_q;
    logic [CHAL_W-1:0] seed_fix;
    logic [CHAL_W-1:0] stepped;

    always_comb begin
        seed_fix = (seed_in == '0) ? CHAL_W'(1) : seed_in;
        stepped  = {r_q.state[CHAL_W-2:0], ^(r_q.state & TAPS)};
        r_d = r_q;
        if (seed_load) begin
            r_d.seed  = seed_fix;
            r_d.state = seed_fix;
        end else if (advance) begin
            r_d.state = wrap ? r_q.seed : stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{seed: CHAL_W'(1), state: CHAL_W'(1)};
        end else begin
            r_q <= r_d;
        end
    end

    assign chal = r_q.state;

    AST_CHAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state != '0); // R5
    AST_LOAD_SEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (chal == r_q.seed)); // R2
endmodule

// File: rtl/pkx_fold.sv
module pkx_fold #(
    parameter int IN_W  = 96,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int NSL  = (IN_W + OUT_W - 1) / OUT_W;
    localparam int PADW = NSL * OUT_W;

    logic [PADW-1:0] padded;
    logic [OUT_W-1:0] acc [NSL+1];

    assign padded = PADW'(din);
    assign acc[0] = '0;

    for (genvar i = 0; i < NSL; i++) begin : g_slice
        assign acc[i+1] = acc[i] ^ padded[i*OUT_W +: OUT_W];
    end

    assign dout = acc[NSL];
endmodule

// File: rtl/pkx_key_mixer.sv
module pkx_key_mixer
    import pkx_pkg::*;
#(
    parameter int UKEY_W   = 64,
    parameter int PUF_W    = 32,
    parameter int KEY_W    = 32,
    parameter int CHAL_W   = 8,
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ukey_load,
    input  logic [UKEY_W-1:0]   ukey_in,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                blk_req,
    output logic                blk_rdy,
    output logic                puf_req,
    output logic [CHAL_W-1:0]   puf_chal,
    input  logic                puf_ack,
    input  logic [PUF_W-1:0]    puf_word,
    output logic [KEY_W-1:0]    key_out,
    output logic                key_vld
);
    localparam int CAT_W = UKEY_W + PUF_W;

    typedef struct packed {
        pkx_state_e          state;
        logic [UKEY_W-1:0]   ukey;
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] cnt;
        logic [KEY_W-1:0]    key;
        logic                vld;
    } mix_regs_t;

    mix_regs_t r_d, r_q;
    logic seed_load, advance, wrap;
    logic [KEY_W-1:0] folded;
    logic [PERIOD_W-1:0] cnt_inc;

    pkx_chal_gen #(.CHAL_W(CHAL_W)) i_chal_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_load(seed_load),
        .seed_in  (ukey_in[CHAL_W-1:0]),
        .advance  (advance),
        .wrap     (wrap),
        .chal     (puf_chal)
    );

    pkx_fold #(.IN_W(CAT_W), .OUT_W(KEY_W)) i_fold (
        .din (CAT_W'({r_q.ukey, puf_word})),
        .dout(folded)
    );

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        seed_load = 1'b0;
        advance   = 1'b0;
        wrap      = 1'b0;
        cnt_inc   = r_q.cnt + PERIOD_W'(1);
        if (ukey_load) begin
            r_d.ukey   = ukey_in;
            r_d.period = (period_in == '0) ? PERIOD_W'(1) : period_in;
            r_d.cnt    = '0;
            r_d.state  = ST_IDLE;
            seed_load  = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (blk_req) r_d.state = ST_FETCH;
                end
                ST_FETCH: begin
                    if (puf_ack) begin
                        r_d.key   = folded;
                        r_d.vld   = 1'b1;
                        r_d.state = ST_IDLE;
                        advance   = 1'b1;
                        if (cnt_inc >= r_q.period) begin
                            wrap    = 1'b1;
                            r_d.cnt = '0;
                        end else begin
                            r_d.cnt = cnt_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_EMPTY, ukey: '0, period: PERIOD_W'(1),
                     cnt: '0, key: '0, vld: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign blk_rdy = (r_q.state == ST_IDLE);
    assign puf_req = (r_q.state == ST_FETCH);
    assign key_out = r_q.key;
    assign key_vld = r_q.vld;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (puf_req && !puf_ack && !ukey_load) |=> (puf_req && $stable(puf_chal))); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        puf_req |-> !blk_rdy); // R3
    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (puf_req && puf_ack && !ukey_load) |=> (key_vld && !puf_req)); // R4
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_vld |=> !key_vld); // R4
    AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ukey_load |=> (!puf_req && !key_vld && blk_rdy)); // R7
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_EMPTY) |-> (r_q.cnt < r_q.period)); // R6
endmodule

// File: tb/test_pkx_key_mixer.sv
module test_pkx_key_mixer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ukey_load = 1'b0;
    logic [63:0] ukey_in = '0;
    logic [7:0]  period_in = '0;
    logic        blk_req = 1'b0;
    logic        blk_rdy;
    logic        puf_req;
    logic [7:0]  puf_chal;
    logic        puf_ack = 1'b0;
    logic [31:0] puf_word = '0;
    logic [31:0] key_out;
    logic        key_vld;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic [63:0] m_ukey;
    logic [7:0]  m_seed, m_state, m_period, m_cnt;

    always #10 clk = ~clk;

    pkx_key_mixer i_pkx_key_mixer (
        .clk(clk), .rst_n(rst_n), .ukey_load(ukey_load), .ukey_in(ukey_in),
        .period_in(period_in), .blk_req(blk_req), .blk_rdy(blk_rdy),
        .puf_req(puf_req), .puf_chal(puf_chal), .puf_ack(puf_ack),
        .puf_word(puf_word), .key_out(key_out), .key_vld(key_vld)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] puf_fn(input logic [7:0] c);
        return {c, ~c, c ^ 8'h5A, c + 8'd3};
    endfunction

    function automatic logic [7:0] lfsr_next(input logic [7:0] s);
        return {s[6:0], ^(s & 8'hB8)};
    endfunction

    // monitor: pops expected keys when the design raises key_vld
    always @(negedge clk) begin
        if (rst_n && key_vld) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected key_vld", 64'd1, 64'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {32'd0, key_out}, {32'd0, e});
            end
        end
    end

    task automatic load_key(input logic [63:0] k, input logic [7:0] per);
        @(negedge clk);
        ukey_load = 1'b1; ukey_in = k; period_in = per;
        @(negedge clk);
        ukey_load = 1'b0;
        m_ukey = k;
        m_seed = (k[7:0] == 8'd0) ? 8'd1 : k[7:0];
        m_state = m_seed;
        m_period = (per == 8'd0) ? 8'd1 : per;
        m_cnt = 0;
        check("R2 ready after load", {63'd0, blk_rdy}, 64'd1);
        check("R7 no req after load", {63'd0, puf_req}, 64'd0);
    endtask

    // driver: one fetch, expected key pushed to scoreboard
    task automatic fetch(input int delay, input bit poke);
        logic [31:0] w;
        blk_req = 1'b1;
        @(negedge clk);
        blk_req = 1'b0;
        check("R3 puf_req up", {63'd0, puf_req}, 64'd1);
        check("R3 blk_rdy down", {63'd0, blk_rdy}, 64'd0);
        check("R5 R6 challenge", {56'd0, puf_chal}, {56'd0, m_state});
        for (int i = 0; i < delay; i++) begin
            if (poke) blk_req = 1'b1;
            @(negedge clk);
            blk_req = 1'b0;
            check("R3 chal held", {56'd0, puf_chal}, {56'd0, m_state});
        end
        w = puf_fn(puf_chal);
        exp_q.push_back(m_ukey[63:32] ^ m_ukey[31:0] ^ w);
        tag_q.push_back("R4 key value");
        puf_ack = 1'b1; puf_word = w;
        @(negedge clk);
        puf_ack = 1'b0;
        check("R4 vld pulse", {63'd0, key_vld}, 64'd1);
        check("R4 req dropped", {63'd0, puf_req}, 64'd0);
        m_cnt = m_cnt + 1;
        if (m_cnt >= m_period) begin
            m_cnt = 0; m_state = m_seed;
        end else begin
            m_state = lfsr_next(m_state);
        end
        @(negedge clk);
        check("R4 vld single", {63'd0, key_vld}, 64'd0);
        if (poke) check("R3 ignored req no fetch", {63'd0, puf_req}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset puf_req", {63'd0, puf_req}, 64'd0);
        check("R1 reset key_vld", {63'd0, key_vld}, 64'd0);
        check("R1 reset blk_rdy", {63'd0, blk_rdy}, 64'd0);
        rst_n = 1'b1;
        blk_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        blk_req = 1'b0;
        check("R1 no fetch before load", {63'd0, puf_req}, 64'd0);

        // R5: period large, plain stepping
        load_key(64'h0123_4567_89AB_CD3C, 8'd20);
        for (int i = 0; i < 6; i++) fetch(i % 3, 1'b0);

        // R6: period 3 wraps
        load_key(64'hFEDC_BA98_7654_3291, 8'd3);
        for (int i = 0; i < 7; i++) fetch(1, 1'b0);

        // R6: period 0 acts as 1
        load_key(64'h1111_2222_3333_44A7, 8'd0);
        for (int i = 0; i < 3; i++) fetch(0, 1'b0);

        // R2: zero low byte seeds with 1
        load_key(64'hA5A5_5A5A_C3C3_0F00, 8'd5);
        fetch(2, 1'b0);
        fetch(0, 1'b0);

        // R3: requests during fetch are ignored
        fetch(3, 1'b1);
        fetch(1, 1'b0);

        // R7: load during fetch aborts
        blk_req = 1'b1;
        @(negedge clk);
        blk_req = 1'b0;
        @(negedge clk);
        check("R7 fetch pending", {63'd0, puf_req}, 64'd1);
        load_key(64'h0F0F_F0F0_1234_5678, 8'd4);
        @(negedge clk);
        check("R7 no key for aborted", {63'd0, key_vld}, 64'd0);
        fetch(1, 1'b0);
        fetch(0, 1'b0);

        repeat (3) @(negedge clk);
        check("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule